// File: doc/BRIEF.md
# Cell Output Header Formatter

This block sits on the output side of a cell path and serves a polled output bus on which it acts as a slave. An external master polls port addresses. On a poll of this port's address, the block answers with a registered cell-available flag. The master then selects the port to start a transfer and pulls words one per cycle with a read strobe. The block emits each fixed-length cell as a short header sequence followed by the payload. The payload comes from a ready/valid source. Header fields come from the cell buffer, which is outside this block.

A static strap picks the bus width. In 8-bit mode every word is one byte on the low lane. In 16-bit mode each word carries two octets. A configuration input decides whether the optional H5/UDF word is sent. Another input can move the logical channel number into the low five bits of that word, in place of a separate leading channel word. The bits above the channel are then filled from a writable extended match register. The format is captured when a transfer starts, so it stays fixed for the whole cell.

Sometimes the master selects the port after the last poll reported no cell. The block records this in a sticky transfer-error status bit, which is cleared by a status read. The status bit drives an active-low interrupt, which can be enabled or disabled.

Top module: `cof_cell_formatter`

## Requirements
- R1: With `bus8`=1, a cell is, in order: the channel word {000, chan_id} when present; then the header bytes hdr[31:24], hdr[23:16], hdr[15:8], hdr[7:0]; then the H5 byte when present; then 48 payload bytes taken from pl_data[7:0]. All of these appear on out_data[7:0], and out_data[15:8] is zero.
- R2: With `bus8`=0, a cell is, in order: the channel word {11'b0, chan_id} when present; then hdr[31:16] and hdr[15:0]; then the H5/UDF word when present; then 24 payload words taken from pl_data.
- R3: With `cfg_h5_en`=0, the H5 word is omitted. With it at 1, the H5 word is sent: {cell_h5} in 8-bit mode and {cell_h5, cell_udf} in 16-bit mode.
- R4: The channel-in-H5 mode is active when `cfg_chan_in_h5`, `port_slave` and `cfg_h5_en` are all 1. When it is active, the leading channel word is dropped. The H5 word then becomes {xm[2:0], chan_id} in 8-bit mode and {xm[10:0], chan_id} in 16-bit mode.
- R5: The extended match register `xm` resets to zero. It loads `xm_wdata` on a cycle with `xm_wr`=1.
- R6: A poll with `bus_poll`=1 and `bus_addr`=`port_addr` loads `cell_avail` into `out_ca` on the next cycle. A transfer starts only on a select while that flag is 1. Starting a transfer clears the flag, so a second select made without a new poll does not start another cell.
- R7: A select of this port while idle, in slave mode, with the polled flag at 0 sets `sts_xfer_err`. A select made while a cell is in progress is ignored.
- R8: With `port_slave`=0, no transfer error is ever recorded and `cfg_chan_in_h5` has no effect.
- R9: `int_n` is low exactly while `sts_xfer_err` and `cfg_xfer_ie` are both 1. A `sts_rd` pulse clears the status on the next cycle, unless a new error occurs in that same cycle.
- R10: A word is presented with `out_valid` in the cycle after a cycle with `bus_rd`=1 that can advance. A payload word can advance only while `pl_valid`=1. `out_soc` marks the first word of a cell and `out_eoc` marks the last.
- R11: Changing the strap or any configuration input while a cell is in progress does not alter that cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus8 | input | 1 | Width strap: 1 = 8-bit words, 0 = 16-bit words |
| port_slave | input | 1 | 1 = port acts as a bus slave |
| cfg_h5_en | input | 1 | Send the H5/UDF word |
| cfg_chan_in_h5 | input | 1 | Carry the channel in the H5/UDF word |
| cfg_xfer_ie | input | 1 | Transfer-error interrupt enable |
| xm_wr | input | 1 | Extended match register write strobe |
| xm_wdata | input | 11 | Extended match register write data |
| port_addr | input | 5 | This port's poll/select address |
| chan_id | input | 5 | Logical channel number |
| cell_avail | input | 1 | Buffer holds a complete cell |
| cell_hdr | input | 32 | Header octets H1..H4, H1 in the top byte |
| cell_h5 | input | 8 | H5 octet |
| cell_udf | input | 8 | UDF octet |
| pl_valid | input | 1 | Payload source valid |
| pl_data | input | 16 | Payload word (low byte used in 8-bit mode) |
| pl_ready | output | 1 | Payload word taken this cycle when valid |
| bus_poll | input | 1 | Master poll strobe |
| bus_sel | input | 1 | Master select (start of transfer) strobe |
| bus_addr | input | 5 | Address of the poll or select |
| bus_rd | input | 1 | Master read strobe |
| out_ca | output | 1 | Cell-available answer from the last poll |
| out_valid | output | 1 | out_data holds a cell word |
| out_soc | output | 1 | First word of a cell |
| out_eoc | output | 1 | Last word of a cell |
| out_data | output | 16 | Cell word |
| sts_rd | input | 1 | Status read; clears the transfer-error bit |
| sts_xfer_err | output | 1 | Sticky transfer-error status |
| int_n | output | 1 | Active-low interrupt |

## Verification
The bench sweeps all sixteen combinations of width strap, H5 include, channel-in-H5 and slave mode, both with and without payload stalls. It compares every emitted word with a sequence built arithmetically. A formatter that handled the leading channel word or the H5 packing wrongly would show up here as a shifted sequence or as wrong upper bits in the H5 word. In every cell the configuration is flipped partway through and an extra select is issued. If the format were not latched, or if selects were not ignored while busy, the cell would be corrupted or restarted, or a false error would be raised. Further cases cover error detection: a select without a new poll, a select after a negative poll, a read that coincides with a fresh error, and master mode. A design that did not consume the polled flag, or that cleared the status over a fresh error, would fail these cases.

// File: rtl/cof_pkg.sv
// Package: shared types for the cell output header formatter.
// Assumes: one phase per word kind; a sub-counter indexes within a phase.
package cof_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ADDR = 3'd1,
        ST_HDR  = 3'd2,
        ST_H5   = 3'd3,
        ST_PAY  = 3'd4
    } cof_state_e;

    typedef struct packed {
        logic bus8;
        logic h5_en;
        logic chan_h5;
    } cof_fmt_t;
endpackage

// File: rtl/cof_poll_ctrl.sv
// Module: poll answer, select decode and transfer-error status/interrupt.
// Assumes: strobes are single-cycle; a select while busy is ignored.
module cof_poll_ctrl #(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_slave,
    input  logic [ADDR_W-1:0] port_addr,
    input  logic              cell_avail,
    input  logic              bus_poll,
    input  logic              bus_sel,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              busy,
    input  logic              sts_rd,
    input  logic              xfer_ie,
    output logic              out_ca,
    output logic              start,
    output logic              sts_xfer_err,
    output logic              int_n
);
    logic polled_ca;
    logic hit_poll;
    logic hit_sel;
    logic err_now;

    // Address decode of poll and select strobes
    always_comb begin
        hit_poll = bus_poll && (bus_addr == port_addr);
        hit_sel  = bus_sel && (bus_addr == port_addr);
        start    = hit_sel && !busy && polled_ca;
        err_now  = hit_sel && !busy && !polled_ca && port_slave;
    end

    // Last polled cell-available value; consumed by a start
    always_ff @(posedge clk) begin
        if (!rst_n)        polled_ca <= 1'b0;
        else if (hit_poll) polled_ca <= cell_avail;
        else if (start)    polled_ca <= 1'b0;
    end

    // Sticky transfer-error status; a new error wins over a read
    always_ff @(posedge clk) begin
        if (!rst_n)       sts_xfer_err <= 1'b0;
        else if (err_now) sts_xfer_err <= 1'b1;
        else if (sts_rd)  sts_xfer_err <= 1'b0;
    end

    // Poll answer and interrupt outputs
    always_comb begin
        out_ca = polled_ca;
        int_n  = !(sts_xfer_err && xfer_ie);
    end

    assert_err_on_bad_select_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_addr == port_addr && !busy && !out_ca && port_slave) |=> sts_xfer_err);

    assert_no_err_in_master_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !port_slave |=> !$rose(sts_xfer_err));

    assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_rd && !bus_sel) |=> !sts_xfer_err);

    assert_start_consumes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !bus_poll) |=> !out_ca);
endmodule

// File: rtl/cof_word_seq.sv
// Module: word sequencer; latches the cell format at start and steps
// through channel, header, H5 and payload phases on each read.
// Assumes: the start pulse is only given while idle.
module cof_word_seq
    import cof_pkg::*;
#(
    parameter int PL_BYTES = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  cof_fmt_t         fmt_in,
    input  logic             bus_rd,
    input  logic             pl_valid,
    output cof_state_e       state,
    output logic [1:0]       hdr_idx,
    output cof_fmt_t         fmt,
    output logic             advance,
    output logic             pl_ready,
    output logic             first,
    output logic             last,
    output logic             busy
);
    localparam int PL_WORDS16 = PL_BYTES / 2;
    localparam int CNT_W      = $clog2(PL_BYTES);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] hdr_last;
    logic [CNT_W-1:0] pl_last;

    // Phase limits from the latched format
    always_comb begin
        hdr_last = fmt.bus8 ? CNT_W'(3) : CNT_W'(1);
        pl_last  = fmt.bus8 ? CNT_W'(PL_BYTES - 1) : CNT_W'(PL_WORDS16 - 1);
        busy     = (state != ST_IDLE);
        advance  = bus_rd && busy && ((state != ST_PAY) || pl_valid);
        pl_ready = bus_rd && (state == ST_PAY);
        last     = (state == ST_PAY) && (cnt == pl_last);
        hdr_idx  = cnt[1:0];
    end

    // Phase and sub-counter stepping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            fmt   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    fmt   <= fmt_in;
                    cnt   <= '0;
                    state <= fmt_in.chan_h5 ? ST_HDR : ST_ADDR;
                end
                ST_ADDR: if (advance) begin
                    state <= ST_HDR;
                    cnt   <= '0;
                end
                ST_HDR: if (advance) begin
                    if (cnt == hdr_last) begin
                        cnt   <= '0;
                        state <= fmt.h5_en ? ST_H5 : ST_PAY;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_H5: if (advance) begin
                    state <= ST_PAY;
                    cnt   <= '0;
                end
                ST_PAY: if (advance) begin
                    if (last) begin
                        state <= ST_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // First-word flag for start-of-cell marking
    always_ff @(posedge clk) begin
        if (!rst_n)        first <= 1'b0;
        else if (start && state == ST_IDLE) first <= 1'b1;
        else if (advance)  first <= 1'b0;
    end

    // Checker: words emitted per cell against the latched format
    logic [CNT_W:0] chk_words;
    logic [CNT_W:0] chk_expect;
    always_comb begin
        chk_expect = (CNT_W+1)'(fmt.chan_h5 ? 0 : 1)
                   + (CNT_W+1)'(fmt.bus8 ? 4 : 2)
                   + (CNT_W+1)'(fmt.h5_en ? 1 : 0)
                   + (CNT_W+1)'(fmt.bus8 ? PL_BYTES : PL_WORDS16);
    end
    // Count words advanced in the current cell
    always_ff @(posedge clk) begin
        if (!rst_n)                     chk_words <= '0;
        else if (advance && last)       chk_words <= '0;
        else if (advance)               chk_words <= chk_words + 1'b1;
    end

    assert_cell_length_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && last) |-> (chk_words + 1'b1 == chk_expect));

    assert_start_leaves_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && state == ST_IDLE) |=> (state != ST_IDLE));

    assert_no_chan_word_in_h5_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR) |-> !fmt.chan_h5);
endmodule

// File: rtl/cof_word_mux.sv
// Module: assembles the current output word from phase, index and format.
// Assumes: CHAN_W < 8 so the channel fits under the match bits in an H5 byte.
module cof_word_mux
    import cof_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CHAN_W = 5
) (
    input  cof_state_e          state,
    input  logic [1:0]          hdr_idx,
    input  cof_fmt_t            fmt,
    input  logic [CHAN_W-1:0]   chan_id,
    input  logic [31:0]         cell_hdr,
    input  logic [7:0]          cell_h5,
    input  logic [7:0]          cell_udf,
    input  logic [DATA_W-CHAN_W-1:0] xm,
    input  logic [DATA_W-1:0]   pl_data,
    output logic [DATA_W-1:0]   word
);
    localparam int XM8_W = 8 - CHAN_W;

    logic [7:0] hdr_byte;
    logic [7:0] h5_byte;

    // Header byte pick and 8-bit H5 packing
    always_comb begin
        case (hdr_idx)
            2'd0:    hdr_byte = cell_hdr[31:24];
            2'd1:    hdr_byte = cell_hdr[23:16];
            2'd2:    hdr_byte = cell_hdr[15:8];
            default: hdr_byte = cell_hdr[7:0];
        endcase
        h5_byte = fmt.chan_h5 ? {xm[XM8_W-1:0], chan_id} : cell_h5;
    end

    // Word selection per phase and width
    always_comb begin
        word = '0;
        case (state)
            ST_ADDR: word = DATA_W'(chan_id);
            ST_HDR: begin
                if (fmt.bus8)          word = DATA_W'(hdr_byte);
                else if (hdr_idx[0])   word = cell_hdr[15:0];
                else                   word = cell_hdr[31:16];
            end
            ST_H5: begin
                if (fmt.bus8)          word = DATA_W'(h5_byte);
                else if (fmt.chan_h5)  word = {xm, chan_id};
                else                   word = {cell_h5, cell_udf};
            end
            ST_PAY: word = fmt.bus8 ? DATA_W'(pl_data[7:0]) : pl_data;
            default: word = '0;
        endcase
    end
endmodule

// File: rtl/cof_cell_formatter.sv
// Module: top of the cell output header formatter. Holds the extended
// match register and the registered output word; wires poll control,
// sequencer and word mux.
// Assumes: header inputs are stable while a cell is being read.
module cof_cell_formatter
    import cof_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int CHAN_W   = 5,
    parameter int DATA_W   = 16,
    parameter int PL_BYTES = 48,
    localparam int XM_W    = DATA_W - CHAN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus8,
    input  logic              port_slave,
    input  logic              cfg_h5_en,
    input  logic              cfg_chan_in_h5,
    input  logic              cfg_xfer_ie,
    input  logic              xm_wr,
    input  logic [XM_W-1:0]   xm_wdata,
    input  logic [ADDR_W-1:0] port_addr,
    input  logic [CHAN_W-1:0] chan_id,
    input  logic              cell_avail,
    input  logic [31:0]       cell_hdr,
    input  logic [7:0]        cell_h5,
    input  logic [7:0]        cell_udf,
    input  logic              pl_valid,
    input  logic [DATA_W-1:0] pl_data,
    output logic              pl_ready,
    input  logic              bus_poll,
    input  logic              bus_sel,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    output logic              out_ca,
    output logic              out_valid,
    output logic              out_soc,
    output logic              out_eoc,
    output logic [DATA_W-1:0] out_data,
    input  logic              sts_rd,
    output logic              sts_xfer_err,
    output logic              int_n
);
    logic [XM_W-1:0] xm;
    cof_fmt_t        fmt_in;
    cof_fmt_t        fmt;
    cof_state_e      state;
    logic [1:0]      hdr_idx;
    logic            start;
    logic            advance;
    logic            first;
    logic            last;
    logic            busy;
    logic [DATA_W-1:0] word;

    // Extended match register, zero after reset
    always_ff @(posedge clk) begin
        if (!rst_n)     xm <= '0;
        else if (xm_wr) xm <= xm_wdata;
    end

    // Effective format from strap and configuration
    always_comb begin
        fmt_in.bus8    = bus8;
        fmt_in.h5_en   = cfg_h5_en;
        fmt_in.chan_h5 = cfg_chan_in_h5 && port_slave && cfg_h5_en;
    end

    cof_poll_ctrl #(.ADDR_W(ADDR_W)) u_poll (
        .clk          (clk),
        .rst_n        (rst_n),
        .port_slave   (port_slave),
        .port_addr    (port_addr),
        .cell_avail   (cell_avail),
        .bus_poll     (bus_poll),
        .bus_sel      (bus_sel),
        .bus_addr     (bus_addr),
        .busy         (busy),
        .sts_rd       (sts_rd),
        .xfer_ie      (cfg_xfer_ie),
        .out_ca       (out_ca),
        .start        (start),
        .sts_xfer_err (sts_xfer_err),
        .int_n        (int_n)
    );

    cof_word_seq #(.PL_BYTES(PL_BYTES)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .fmt_in   (fmt_in),
        .bus_rd   (bus_rd),
        .pl_valid (pl_valid),
        .state    (state),
        .hdr_idx  (hdr_idx),
        .fmt      (fmt),
        .advance  (advance),
        .pl_ready (pl_ready),
        .first    (first),
        .last     (last),
        .busy     (busy)
    );

    cof_word_mux #(.DATA_W(DATA_W), .CHAN_W(CHAN_W)) u_mux (
        .state    (state),
        .hdr_idx  (hdr_idx),
        .fmt      (fmt),
        .chan_id  (chan_id),
        .cell_hdr (cell_hdr),
        .cell_h5  (cell_h5),
        .cell_udf (cell_udf),
        .xm       (xm),
        .pl_data  (pl_data),
        .word     (word)
    );

    // Registered output word with cell markers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_soc   <= 1'b0;
            out_eoc   <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= advance;
            out_soc   <= advance && first;
            out_eoc   <= advance && last;
            if (advance) out_data <= word;
        end
    end

    assert_soc_with_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_soc |-> (out_valid && !out_eoc));

    assert_eoc_with_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_eoc |-> out_valid);

    assert_byte_lane_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && fmt.bus8) |-> (out_data[DATA_W-1:8] == '0));

    assert_xm_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        xm_wr |=> (xm == $past(xm_wdata)));
endmodule

// File: tb/cof_cell_formatter_bench.sv
// Bench: sweeps width/format/mode combinations and error scenarios,
// computing every expected word arithmetically.
module cof_cell_formatter_bench;
    localparam logic [4:0] PA = 5'd9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus8 = 1'b0, port_slave = 1'b1, cfg_h5_en = 1'b1;
    logic        cfg_chan_in_h5 = 1'b0, cfg_xfer_ie = 1'b1;
    logic        xm_wr = 1'b0;
    logic [10:0] xm_wdata = '0;
    logic [4:0]  chan_id = '0;
    logic        cell_avail = 1'b0;
    logic [31:0] cell_hdr = '0;
    logic [7:0]  cell_h5 = '0, cell_udf = '0;
    logic        pl_valid;
    logic [15:0] pl_data;
    logic        pl_ready;
    logic        bus_poll = 1'b0, bus_sel = 1'b0, bus_rd = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        out_ca, out_valid, out_soc, out_eoc;
    logic [15:0] out_data;
    logic        sts_rd = 1'b0;
    logic        sts_xfer_err, int_n;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int pl_idx = 0;
    logic pl_clr = 1'b0;
    logic stall = 1'b0;
    logic [7:0] seed = '0;

    always #4 clk = ~clk;

    cof_cell_formatter u_cof_cell_formatter (
        .clk(clk), .rst_n(rst_n), .bus8(bus8), .port_slave(port_slave),
        .cfg_h5_en(cfg_h5_en), .cfg_chan_in_h5(cfg_chan_in_h5),
        .cfg_xfer_ie(cfg_xfer_ie), .xm_wr(xm_wr), .xm_wdata(xm_wdata),
        .port_addr(PA), .chan_id(chan_id), .cell_avail(cell_avail),
        .cell_hdr(cell_hdr), .cell_h5(cell_h5), .cell_udf(cell_udf),
        .pl_valid(pl_valid), .pl_data(pl_data), .pl_ready(pl_ready),
        .bus_poll(bus_poll), .bus_sel(bus_sel), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .out_ca(out_ca), .out_valid(out_valid),
        .out_soc(out_soc), .out_eoc(out_eoc), .out_data(out_data),
        .sts_rd(sts_rd), .sts_xfer_err(sts_xfer_err), .int_n(int_n)
    );

    function automatic logic [15:0] pl_word(int j, logic [7:0] s);
        pl_word = {8'(j * 7) + s, 8'(j * 13 + 1) + s};
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (pl_clr) pl_idx <= 0;
        else if (pl_ready && pl_valid) pl_idx <= pl_idx + 1;
    end
    assign pl_valid = !(stall && (cyc % 4 == 1));
    assign pl_data  = pl_word(pl_idx, seed);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_test();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_test();
    end

    // Expected word k of a cell for the given format
    function automatic logic [15:0] exp_word(int k, logic b8, logic h5, logic eff,
                                              logic [4:0] ch, logic [10:0] xmv,
                                              logic [31:0] hdr, logic [7:0] h5b,
                                              logic [7:0] udf, logic [7:0] s);
        int j;
        j = k;
        if (!eff) begin
            if (j == 0) return {11'd0, ch};
            j = j - 1;
        end
        if (b8) begin
            if (j < 4) return {8'd0, hdr[31 - 8*j -: 8]};
            j = j - 4;
        end else begin
            if (j < 2) return (j == 0) ? hdr[31:16] : hdr[15:0];
            j = j - 2;
        end
        if (h5) begin
            if (j == 0) begin
                if (b8) return eff ? {8'd0, xmv[2:0], ch} : {8'd0, h5b};
                return eff ? {xmv, ch} : {h5b, udf};
            end
            j = j - 1;
        end
        return b8 ? {8'd0, pl_word(j, s)[7:0]} : pl_word(j, s);
    endfunction

    // One full cell: poll, select, read, compare every word
    task automatic run_cell(logic b8, logic h5, logic chh5, logic slv,
                            logic do_wr, logic [10:0] xmv, logic stl);
        logic eff;
        int   total, n;
        bit   done;
        @(negedge clk);
        bus8 = b8; cfg_h5_en = h5; cfg_chan_in_h5 = chh5; port_slave = slv;
        stall = stl;
        chan_id = 5'(xmv[4:0] ^ 5'h13);
        cell_hdr = {xmv[7:0], 8'h5C, xmv[10:3], 8'hE1};
        cell_h5 = 8'hB0 ^ xmv[7:0];
        cell_udf = 8'h3D + xmv[7:0];
        seed = xmv[7:0] + 8'(b8);
        if (do_wr) begin xm_wr = 1'b1; xm_wdata = xmv; end
        eff = chh5 && slv && h5;
        total = (eff ? 0 : 1) + (b8 ? 4 : 2) + (h5 ? 1 : 0) + (b8 ? 48 : 24);
        @(negedge clk);
        xm_wr = 1'b0; bus_poll = 1'b1; bus_addr = PA; cell_avail = 1'b1; pl_clr = 1'b1;
        @(negedge clk);
        bus_poll = 1'b0; pl_clr = 1'b0;
        check("R6 poll answer", out_ca, 1);
        bus_sel = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; cell_avail = 1'b0; bus_rd = 1'b1;
        n = 0; done = 0;
        for (int t = 0; t < 400 && !done; t++) begin
            @(negedge clk);
            bus_sel = 1'b0;
            if (t == 0) check("R10 first word next cycle", {out_valid, out_soc}, 2'b11);
            if (out_valid) begin
                check("R1/R2/R3/R4/R11 word", out_data,
                      exp_word(n, b8, h5, eff, chan_id, do_wr ? xmv : 11'd0,
                               cell_hdr, cell_h5, cell_udf, seed));
                if (n == 1) begin
                    bus8 = !b8; cfg_h5_en = !h5; cfg_chan_in_h5 = !chh5; port_slave = !slv;
                end
                if (n == 8) begin bus_sel = 1'b1; bus_addr = PA; end
                if (out_eoc) begin
                    done = 1;
                    check("R10 eoc on last word", n, total - 1);
                end
                n++;
            end
        end
        bus_rd = 1'b0; bus_sel = 1'b0;
        bus8 = b8; cfg_h5_en = h5; cfg_chan_in_h5 = chh5; port_slave = slv;
        check("R1/R2 word count", n, total);
        check("R7 select while busy ignored", sts_xfer_err, 0);
    endtask

    task automatic pulse_sel();
        @(negedge clk);
        bus_sel = 1'b1; bus_addr = PA;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 reset int_n", int_n, 1);
        check("R7 reset status", sts_xfer_err, 0);
        check("R10 reset out_valid", out_valid, 0);
        check("R6 reset out_ca", out_ca, 0);
        check("R10 reset pl_ready", pl_ready, 0);

        // R5: reset value of the match register seen through H5 packing
        run_cell(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 11'h7FF, 1'b0);
        run_cell(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 11'h7FF, 1'b0);

        // Sweep of width, H5 include, channel-in-H5, slave, with/without stalls
        for (int c = 0; c < 32; c++) begin
            run_cell(c[0], c[1], c[2], c[3], 1'b1, 11'(c * 83 + 11'h2A5), c[4]);
        end

        // R6/R7: select without a fresh poll after a cell
        port_slave = 1'b1; cfg_xfer_ie = 1'b1;
        pulse_sel();
        check("R7 stale select sets status", sts_xfer_err, 1);
        check("R9 interrupt asserted", int_n, 0);
        check("R6 no cell started", out_valid, 0);

        // R9: status read clears next cycle
        @(negedge clk); sts_rd = 1'b1;
        @(negedge clk); sts_rd = 1'b0;
        check("R9 read clears status", sts_xfer_err, 0);
        check("R9 interrupt released", int_n, 1);

        // R7: negative poll then select; other address ignored
        @(negedge clk); bus_poll = 1'b1; bus_addr = PA; cell_avail = 1'b0;
        @(negedge clk); bus_poll = 1'b0;
        check("R6 negative poll answer", out_ca, 0);
        bus_sel = 1'b1; bus_addr = PA ^ 5'd1;
        @(negedge clk); bus_sel = 1'b0;
        check("R7 other address ignored", sts_xfer_err, 0);
        pulse_sel();
        check("R7 select after negative poll", sts_xfer_err, 1);

        // R9: read in the same cycle as a new error keeps status
        @(negedge clk); sts_rd = 1'b1; bus_sel = 1'b1; bus_addr = PA;
        @(negedge clk); sts_rd = 1'b0; bus_sel = 1'b0;
        check("R9 new error beats read", sts_xfer_err, 1);
        @(negedge clk); sts_rd = 1'b1;
        @(negedge clk); sts_rd = 1'b0;

        // R9: enable off keeps int_n high
        cfg_xfer_ie = 1'b0;
        pulse_sel();
        check("R9 status set with enable off", sts_xfer_err, 1);
        check("R9 int_n high with enable off", int_n, 1);
        @(negedge clk); sts_rd = 1'b1;
        @(negedge clk); sts_rd = 1'b0; cfg_xfer_ie = 1'b1;

        // R8: master mode records no error
        port_slave = 1'b0;
        pulse_sel();
        check("R8 no error in master mode", sts_xfer_err, 0);
        check("R8 int_n idle in master mode", int_n, 1);
        port_slave = 1'b1;

        repeat (2) @(negedge clk);
        finish_test();
    end
endmodule